// File: doc/BRIEF.md
# Flash Block Lock Manager

This block holds the write-protection state of every erase block in a boot-block flash array. The array has eight 4 Kword parameter blocks and `MAIN_BLOCKS` main blocks of 32 Kwords each. A parameter selects whether the parameter blocks sit at the bottom or at the top of the word address space. Lock, unlock and lock-down requests arrive with a word address. The address is decoded to a block index in the same cycle, and that block's state is updated on the next clock edge.

Each block keeps two bits: a locked bit and a lock-down mark. The mark only has force while the active-low write-protect pin is low. In that state a marked block reads as locked and cannot be unlocked. While the pin is high, a marked block behaves as an ordinary locked block. When the pin goes low again, every marked block is locked again. A combinational status port answers lock queries. A program-request port gives the program/erase sequencer a one-cycle-later go or lock-error answer.

Top module: `flash_lock_mgr`

## Requirements
- R1: Block index 0 is at the lowest address. With `TOP_BOOT`=0, words 0..0x7FFF form parameter blocks 0..7 (4 Kwords each) and main block j (j from 0) starts at 0x8000*(j+1). With `TOP_BOOT`=1, main block j starts at 0x8000*j, and parameter block k starts at 0x8000*`MAIN_BLOCKS` + 0x1000*k and has index `MAIN_BLOCKS`+k.
- R2: While `rst_n` is low, and after it is released, every block is locked and carries no lock-down mark.
- R3: With `cmd_valid`=1, `cmd_op`=0 locks and `cmd_op`=1 unlocks the block that contains `cmd_addr`, from any word inside it. Other blocks are unchanged.
- R4: `cmd_op`=2 locks the block and sets its lock-down mark. While `wp_n`=1, a marked block can be unlocked and relocked by command.
- R5: While `wp_n`=0, a marked block reports locked, an unlock command to it has no effect, and programming it is refused.
- R6: `qry_status` is nonzero only when `qry_addr` is the block base plus 2. It then returns bit 0 = locked (effective) and bit 1 = lock-down mark, with bits 15:2 zero.
- R7: A `pgm_req` pulse with `pgm_addr` gives, one clock later, `pgm_go`=1 if the block is unlocked, or else `lock_err`=1. The two are never high together, and neither is high without a request.
- R8: `cmd_op`=3 is ignored.
- R9: Lock-down marks are cleared only by reset. No command removes them.
- R10: When `wp_n` falls, each marked block that had been unlocked becomes locked, and it stays locked after `wp_n` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Active-low write protect; enables lock-down |
| cmd_valid | input | 1 | Lock command strobe |
| cmd_op | input | 2 | 0 lock, 1 unlock, 2 lock-down, 3 ignored |
| cmd_addr | input | ADDR_W | Word address selecting the block |
| qry_addr | input | ADDR_W | Status query address |
| qry_status | output | 16 | Lock status word |
| pgm_req | input | 1 | Program/erase permission request |
| pgm_addr | input | ADDR_W | Target word address |
| pgm_go | output | 1 | Target writable, one cycle after request |
| lock_err | output | 1 | Target locked, one cycle after request |

## Verification
The hardest state to reach is a marked block that was unlocked while write-protect was high and then has the pin lowered and raised again. It must come back locked, keep its mark, and refuse programming in between. The stimulus reaches it through an ordered sequence on one main block: lock-down, unlock with the pin high, lower the pin, attempt unlock and program, raise the pin, and query at each step. A second instance with the top-boot layout checks the mirrored decode.

// File: rtl/flash_lock_mgr.sv
module flash_lock_mgr #(
  parameter int MAIN_BLOCKS = 15,
  parameter bit TOP_BOOT = 1'b0,
  localparam int ADDR_W = $clog2((MAIN_BLOCKS + 1) * 32768)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic [15:0]       qry_status,
  input  logic              pgm_req,
  input  logic [ADDR_W-1:0] pgm_addr,
  output logic              pgm_go,
  output logic              lock_err
);
  localparam int NBLK  = MAIN_BLOCKS + 8;
  localparam int HI_W  = ADDR_W - 15;
  localparam int IDX_W = $clog2(MAIN_BLOCKS + 16);

  localparam logic [1:0] OP_LOCK   = 2'd0;
  localparam logic [1:0] OP_UNLOCK = 2'd1;
  localparam logic [1:0] OP_LDOWN  = 2'd2;

  function automatic logic is_param(input logic [ADDR_W-1:0] a);
    logic [HI_W-1:0] hi;
    hi = a[ADDR_W-1:15];
    if (TOP_BOOT) return hi >= HI_W'(MAIN_BLOCKS);
    else          return hi == '0;
  endfunction

  function automatic logic [IDX_W-1:0] blk_idx(input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] hi, sub;
    hi  = IDX_W'(a[ADDR_W-1:15]);
    sub = IDX_W'(a[14:12]);
    if (TOP_BOOT) return is_param(a) ? IDX_W'(MAIN_BLOCKS) + sub : hi;
    else          return is_param(a) ? sub : hi + IDX_W'(7);
  endfunction

  logic [NBLK-1:0] locked, mark, eff;
  logic [IDX_W-1:0] c_idx, q_idx, p_idx;
  logic c_in, q_in, p_in, q_off2, p_ok;

  assign c_idx = blk_idx(cmd_addr);
  assign q_idx = blk_idx(qry_addr);
  assign p_idx = blk_idx(pgm_addr);
  assign c_in  = c_idx < IDX_W'(NBLK);
  assign q_in  = q_idx < IDX_W'(NBLK);
  assign p_in  = p_idx < IDX_W'(NBLK);

  assign eff = locked | (mark & {NBLK{~wp_n}});

  genvar g;
  generate
    for (g = 0; g < NBLK; g++) begin : g_blk
      logic hit, lk_q, md_q;
      assign hit = cmd_valid && c_in && (c_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lk_q <= 1'b1;
          md_q <= 1'b0;
        end else if (hit && cmd_op == OP_LDOWN) begin
          lk_q <= 1'b1;
          md_q <= 1'b1;
        end else if (hit && cmd_op == OP_LOCK) begin
          lk_q <= 1'b1;
        end else if (hit && cmd_op == OP_UNLOCK && !(md_q && !wp_n)) begin
          lk_q <= 1'b0;
        end else if (md_q && !wp_n) begin
          lk_q <= 1'b1;
        end
      end
      assign locked[g] = lk_q;
      assign mark[g]   = md_q;
    end
  endgenerate

  assign q_off2 = is_param(qry_addr) ? (qry_addr[11:0] == 12'h002)
                                     : (qry_addr[14:0] == 15'h0002);
  assign qry_status = (q_in && q_off2) ? {14'b0, mark[q_idx], eff[q_idx]} : 16'h0000;

  assign p_ok = p_in && !eff[p_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgm_go   <= 1'b0;
      lock_err <= 1'b0;
    end else begin
      pgm_go   <= pgm_req && p_ok;
      lock_err <= pgm_req && !p_ok;
    end
  end
endmodule

// File: rtl/flash_lock_mgr_chk.sv
module flash_lock_mgr_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp_n,
  input logic              cmd_valid,
  input logic [ADDR_W-1:0] qry_addr,
  input logic [15:0]       qry_status,
  input logic              pgm_req,
  input logic              pgm_go,
  input logic              lock_err
);
  logic fresh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fresh <= 1'b1;
    else if (cmd_valid) fresh <= 1'b0;
  end

  a_r2_locked_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh && qry_status != 16'h0) |-> qry_status[1:0] == 2'b01);

  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    qry_status[15:2] == 14'h0);

  a_r5_marked_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && qry_status[1]) |-> qry_status[0]);

  a_r9_mark_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    qry_status[1] |=> (!$stable(qry_addr) || qry_status[1]));

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pgm_go && lock_err));

  a_r7_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_go || lock_err) |-> $past(pgm_req));
endmodule

bind flash_lock_mgr flash_lock_mgr_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
  .qry_addr(qry_addr), .qry_status(qry_status), .pgm_req(pgm_req),
  .pgm_go(pgm_go), .lock_err(lock_err)
);

// File: tb/flash_lock_mgr_tb_top.sv
module flash_lock_mgr_tb_top;
  localparam int AW = 19;
  logic clk = 0, rst_n = 0, wp_n = 1, cmd_valid = 0, pgm_req = 0;
  logic [1:0] cmd_op = 0;
  logic [AW-1:0] cmd_addr = 0, qry_addr = 0, pgm_addr = 0;
  logic [15:0] qst, qst_top;
  logic go, err, go_t, err_t;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flash_lock_mgr #(.MAIN_BLOCKS(15), .TOP_BOOT(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .qry_addr(qry_addr), .qry_status(qst), .pgm_req(pgm_req),
    .pgm_addr(pgm_addr), .pgm_go(go), .lock_err(err));

  flash_lock_mgr #(.MAIN_BLOCKS(15), .TOP_BOOT(1'b1)) dut_top_i (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .qry_addr(qry_addr), .qry_status(qst_top), .pgm_req(pgm_req),
    .pgm_addr(pgm_addr), .pgm_go(go_t), .lock_err(err_t));

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [AW-1:0] a);
    @(negedge clk); cmd_valid = 1; cmd_op = op; cmd_addr = a;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic q(input string req, input logic [AW-1:0] a, input logic [15:0] exp, input bit top = 0);
    qry_addr = a; #1;
    check(req, top ? qst_top : qst, exp);
  endtask

  task automatic pgm(input string req, input logic [AW-1:0] a, input bit exp_go);
    @(negedge clk); pgm_req = 1; pgm_addr = a;
    @(negedge clk); pgm_req = 0;
    check(req, {14'b0, go, err}, {14'b0, exp_go, !exp_go});
  endtask

  task automatic set_wp(input logic v);
    @(negedge clk); wp_n = v; @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  task automatic t_reset;
    q("R2 param0 locked", 19'h00002, 16'h0001);
    q("R2 last main locked", 19'h78002, 16'h0001);
    q("R6 non-status offset", 19'h00003, 16'h0000);
    q("R6 main offset", 19'h08002, 16'h0001);
  endtask

  task automatic t_lock_unlock;
    cmd(2'd1, 19'h03456);
    q("R3 unlocked param3", 19'h03002, 16'h0000);
    q("R1 R3 param2 untouched", 19'h02002, 16'h0001);
    q("R1 R3 param4 untouched", 19'h04002, 16'h0001);
    pgm("R7 program unlocked", 19'h03010, 1'b1);
    pgm("R7 program locked", 19'h02010, 1'b0);
    cmd(2'd3, 19'h04000);
    q("R8 op3 ignored", 19'h04002, 16'h0001);
    cmd(2'd0, 19'h03FFF);
    q("R3 relocked param3", 19'h03002, 16'h0001);
  endtask

  task automatic t_lockdown;
    cmd(2'd2, 19'h10000);
    q("R4 lockdown", 19'h10002, 16'h0003);
    cmd(2'd1, 19'h17000);
    q("R4 unlock with wp high", 19'h10002, 16'h0002);
    @(negedge clk); wp_n = 0;
    q("R5 wp low locks mark", 19'h10002, 16'h0003);
    cmd(2'd1, 19'h10000);
    q("R5 unlock refused", 19'h10002, 16'h0003);
    pgm("R5 program refused", 19'h10004, 1'b0);
    set_wp(1);
    q("R10 stays locked after wp high", 19'h10002, 16'h0003);
    cmd(2'd1, 19'h10000);
    q("R4 unlock again", 19'h10002, 16'h0002);
    cmd(2'd0, 19'h10000);
    q("R9 lock keeps mark", 19'h10002, 16'h0003);
    cmd(2'd1, 19'h10000);
    set_wp(0);
    set_wp(1);
    q("R10 relock on wp pulse", 19'h10002, 16'h0003);
  endtask

  task automatic t_reset_clears;
    do_reset();
    q("R9 reset clears mark", 19'h10002, 16'h0001);
    q("R2 param3 locked again", 19'h03002, 16'h0001);
  endtask

  task automatic t_top;
    cmd(2'd1, 19'h7A123);
    q("R1 top param2 unlocked", 19'h7A002, 16'h0000, 1);
    q("R1 top param1 locked", 19'h79002, 16'h0001, 1);
    q("R1 top main14 locked", 19'h70002, 16'h0001, 1);
    cmd(2'd1, 19'h08000);
    q("R1 top main1 unlocked", 19'h08002, 16'h0000, 1);
    q("R1 top main0 locked", 19'h00002, 16'h0001, 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    q("R2 locked during reset", 19'h00002, 16'h0001);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_lock_unlock();
    t_lockdown();
    t_reset_clears();
    t_top();
    finish_run();
  end
endmodule